// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for a synchronous RGB panel. Two counters walk the frame: a pixel counter for the horizontal position and a line counter for the vertical position. Compare logic turns their values into a data-enable strobe, horizontal and vertical sync pulses, an internal horizontal retrace window, a vertical blanking flag and a one-cycle end-of-frame pulse.

Software programs the geometry through five packed 32-bit timing registers and starts or stops output through a control register. All registers share a simple write port. In continuous mode frames repeat until software clears the enable bit. In single-frame mode the block draws exactly one frame. It then clears its own enable bit and parks both counters at zero until software sets the bit again.

Top module: `crtc_timing`

## Requirements
- R1: After reset both counters are 0, and dataEn, hSync, vSync, hRetrace, vRetrace, frameEnd and videoEn are all low.
- R2: A write with wrEn high stores wrData into the register at wrAddr. Address 0 holds the vertical total in [31:16] and the horizontal total in [15:0]. Address 1 holds the vertical display end in [31:16] and the horizontal display end in [15:0]. Address 2 holds the horizontal retrace end in [31:16] and its start in [15:0]. Address 3 holds the horizontal sync end in [31:16] and its start in [15:0]. Address 4 holds the vertical sync end in [31:16] and its start in [15:0]. Address 5 is control: bit 0 is the enable and bit 1 selects single-frame mode (1) or continuous mode (0). Each write takes effect from the next cycle.
- R3: While enabled, pixCount advances by one each cycle and returns to 0 after it reaches the horizontal total minus 1.
- R4: lineCount advances when pixCount wraps, and returns to 0 after it reaches the vertical total minus 1.
- R5: dataEn is high only while enabled, with pixCount below the horizontal display end and lineCount below the vertical display end.
- R6: hSync is high, active high, while enabled and hsync start <= pixCount < hsync end. vSync is high while enabled and vsync start <= lineCount < vsync end.
- R7: hRetrace is high while enabled and retrace start <= pixCount < retrace end. It follows its own register and does not depend on the sync register.
- R8: vRetrace is high while enabled and lineCount >= the vertical display end.
- R9: frameEnd is a one-cycle pulse on the last pixel of the last line. In the next cycle both counters are 0.
- R10: In single-frame mode the enable bit clears on the cycle after frameEnd, so videoEn reads low. Both counters then stay at 0 until enable is written again, and writing it again draws exactly one more frame.
- R11: While the enable bit is low, both counters are held at 0 from the next cycle on, and every timing output is low.
- R12: A window whose start is not below its end never asserts its output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W (3) | Register address |
| wrData | input | 32 | Register write data |
| pixCount | output | 16 | Horizontal position |
| lineCount | output | 16 | Vertical position |
| dataEn | output | 1 | Active-area data enable |
| hSync | output | 1 | Horizontal sync, active high |
| vSync | output | 1 | Vertical sync, active high |
| hRetrace | output | 1 | Internal horizontal retrace window |
| vRetrace | output | 1 | Vertical blanking flag |
| frameEnd | output | 1 | Last-pixel-of-frame pulse |
| videoEn | output | 1 | Current state of the enable bit |

## Verification
The assertions check the following on every cycle: that the counters step by one, that they return to zero after frameEnd or while the block is disabled, that the single-frame enable clears itself, and that dataEn and hSync never rise while the block is disabled. Only the bench scenarios can show the exact positions of the windows for a given register image. They also show the frame and pulse counts for two different geometries, that an empty sync window stays silent, and that a second single-frame trigger draws exactly one more frame.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int CNT_W     = 16;
  localparam int REG_W     = 2 * CNT_W;
  localparam int NUM_TREG  = 5;
  localparam int CTRL_ADDR = 5;

  // timing register indices
  localparam int IDX_SIZE  = 0;
  localparam int IDX_DEND  = 1;
  localparam int IDX_HRET  = 2;
  localparam int IDX_HSYNC = 3;
  localparam int IDX_VSYNC = 4;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t hTotal;
    cnt_t vTotal;
    cnt_t hDispEnd;
    cnt_t vDispEnd;
    cnt_t hRetStart;
    cnt_t hRetEnd;
    cnt_t hSyncStart;
    cnt_t hSyncEnd;
    cnt_t vSyncStart;
    cnt_t vSyncEnd;
  } timing_t;

  typedef struct packed {
    logic count;
    logic clear;
  } ctrlStrobe_t;
endpackage

// File: rtl/crtc_regs.sv
module crtc_regs
  import crtc_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  output timing_t           timing
);
  logic [NUM_TREG-1:0][REG_W-1:0] bank;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bank <= '0;
    end else if (wrEn) begin
      for (int i = 0; i < NUM_TREG; i++) begin
        if (wrAddr == ADDR_W'(i)) bank[i] <= wrData;
      end
    end
  end

  always_comb begin
    timing.hTotal     = bank[IDX_SIZE][CNT_W-1:0];
    timing.vTotal     = bank[IDX_SIZE][REG_W-1:CNT_W];
    timing.hDispEnd   = bank[IDX_DEND][CNT_W-1:0];
    timing.vDispEnd   = bank[IDX_DEND][REG_W-1:CNT_W];
    timing.hRetStart  = bank[IDX_HRET][CNT_W-1:0];
    timing.hRetEnd    = bank[IDX_HRET][REG_W-1:CNT_W];
    timing.hSyncStart = bank[IDX_HSYNC][CNT_W-1:0];
    timing.hSyncEnd   = bank[IDX_HSYNC][REG_W-1:CNT_W];
    timing.vSyncStart = bank[IDX_VSYNC][CNT_W-1:0];
    timing.vSyncEnd   = bank[IDX_VSYNC][REG_W-1:CNT_W];
  end
endmodule

// File: rtl/crtc_ctrl.sv
module crtc_ctrl
  import crtc_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [1:0]        wrBits,
  input  logic              frameEnd,
  output ctrlStrobe_t       strobe,
  output logic              videoEn,
  output logic              singleMode
);
  logic ctrlHit;
  assign ctrlHit = wrEn && (wrAddr == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      videoEn    <= 1'b0;
      singleMode <= 1'b0;
    end else if (ctrlHit) begin
      videoEn    <= wrBits[0];
      singleMode <= wrBits[1];
    end else if (singleMode && frameEnd) begin
      videoEn <= 1'b0;
    end
  end

  always_comb begin
    strobe.count = videoEn;
    strobe.clear = !videoEn;
  end
endmodule

// File: rtl/crtc_datapath.sv
module crtc_datapath
  import crtc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  timing_t     timing,
  output cnt_t        pixCount,
  output cnt_t        lineCount,
  output logic        dataEn,
  output logic        hSync,
  output logic        vSync,
  output logic        hRetrace,
  output logic        vRetrace,
  output logic        frameEnd
);
  logic lastPix, lastLine;

  function automatic logic inWindow(cnt_t c, cnt_t s, cnt_t e);
    return (c >= s) && (c < e);
  endfunction

  assign lastPix  = (pixCount  == cnt_t'(timing.hTotal - 1'b1));
  assign lastLine = (lineCount == cnt_t'(timing.vTotal - 1'b1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixCount  <= '0;
      lineCount <= '0;
    end else if (strobe.clear) begin
      pixCount  <= '0;
      lineCount <= '0;
    end else if (strobe.count) begin
      if (lastPix) begin
        pixCount  <= '0;
        lineCount <= lastLine ? '0 : cnt_t'(lineCount + 1'b1);
      end else begin
        pixCount <= cnt_t'(pixCount + 1'b1);
      end
    end
  end

  always_comb begin
    dataEn   = strobe.count && (pixCount < timing.hDispEnd) && (lineCount < timing.vDispEnd);
    hSync    = strobe.count && inWindow(pixCount, timing.hSyncStart, timing.hSyncEnd);
    hRetrace = strobe.count && inWindow(pixCount, timing.hRetStart, timing.hRetEnd);
    vSync    = strobe.count && inWindow(lineCount, timing.vSyncStart, timing.vSyncEnd);
    vRetrace = strobe.count && (lineCount >= timing.vDispEnd);
    frameEnd = strobe.count && lastPix && lastLine;
  end
endmodule

// File: rtl/crtc_timing.sv
module crtc_timing
  import crtc_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  output logic [CNT_W-1:0]  pixCount,
  output logic [CNT_W-1:0]  lineCount,
  output logic              dataEn,
  output logic              hSync,
  output logic              vSync,
  output logic              hRetrace,
  output logic              vRetrace,
  output logic              frameEnd,
  output logic              videoEn
);
  timing_t     timing;
  ctrlStrobe_t strobe;
  logic        singleMode;

  crtc_regs #(.ADDR_W(ADDR_W)) uRegs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .timing(timing)
  );

  crtc_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrBits(wrData[1:0]), .frameEnd(frameEnd), .strobe(strobe),
    .videoEn(videoEn), .singleMode(singleMode)
  );

  crtc_datapath uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .timing(timing),
    .pixCount(pixCount), .lineCount(lineCount), .dataEn(dataEn),
    .hSync(hSync), .vSync(vSync), .hRetrace(hRetrace),
    .vRetrace(vRetrace), .frameEnd(frameEnd)
  );
endmodule

// File: rtl/crtc_timing_chk.sv
module crtc_timing_chk
  import crtc_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [CNT_W-1:0]  pixCount,
  input logic [CNT_W-1:0]  lineCount,
  input logic              dataEn,
  input logic              hSync,
  input logic              frameEnd,
  input logic              videoEn,
  input logic              singleMode
);
  logic ctrlWrite;
  assign ctrlWrite = wrEn && (wrAddr == ADDR_W'(CTRL_ADDR));

  // R3
  pix_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (videoEn && $past(videoEn) && pixCount != '0) |-> pixCount == CNT_W'($past(pixCount) + 1'b1));

  // R9
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> (pixCount == '0 && lineCount == '0));

  // R10
  single_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && singleMode && !ctrlWrite) |=> !videoEn);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !videoEn |=> (pixCount == '0 && lineCount == '0));

  // R5
  de_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataEn |-> videoEn);

  // R6
  hsync_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    hSync |-> videoEn);
endmodule

bind crtc_timing crtc_timing_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
  .pixCount(pixCount), .lineCount(lineCount), .dataEn(dataEn),
  .hSync(hSync), .frameEnd(frameEnd), .videoEn(videoEn),
  .singleMode(singleMode)
);

// File: tb/sim_crtc_timing.sv
module sim_crtc_timing;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [15:0] pixCount, lineCount;
  logic dataEn, hSync, vSync, hRetrace, vRetrace, frameEnd, videoEn;

  int checks = 0;
  int errors = 0;
  bit cmpOn = 1'b0;

  // reference model state
  bit [31:0] mreg [5];
  bit mEn, mSingle;
  int mh, mv;

  always #10 clk = ~clk;

  crtc_timing u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pixCount(pixCount), .lineCount(lineCount), .dataEn(dataEn),
    .hSync(hSync), .vSync(vSync), .hRetrace(hRetrace), .vRetrace(vRetrace),
    .frameEnd(frameEnd), .videoEn(videoEn)
  );

  function automatic int lo(bit [31:0] r); return int'(r[15:0]); endfunction
  function automatic int hi(bit [31:0] r); return int'(r[31:16]); endfunction
  function automatic int lastOf(int tot); return (tot + 65535) % 65536; endfunction

  function automatic bit expFe();
    return mEn && mh == lastOf(lo(mreg[0])) && mv == lastOf(hi(mreg[0]));
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 5; i++) mreg[i] = '0;
      mEn = 0; mSingle = 0; mh = 0; mv = 0;
    end else begin
      bit clr;
      clr = mSingle && expFe();
      if (!mEn) begin
        mh = 0; mv = 0;
      end else if (mh == lastOf(lo(mreg[0]))) begin
        mh = 0;
        mv = (mv == lastOf(hi(mreg[0]))) ? 0 : mv + 1;
      end else begin
        mh = mh + 1;
      end
      if (wrEn && wrAddr == 3'd5) begin
        mEn = wrData[0]; mSingle = wrData[1];
      end else begin
        if (clr) mEn = 0;
        if (wrEn && wrAddr < 3'd5) mreg[wrAddr] = wrData;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && cmpOn) begin
      chk("R3 pixCount", int'(pixCount), mh);
      chk("R4 lineCount", int'(lineCount), mv);
      chk("R5 dataEn", int'(dataEn), int'(mEn && mh < lo(mreg[1]) && mv < hi(mreg[1])));
      chk("R6 hSync", int'(hSync), int'(mEn && mh >= lo(mreg[3]) && mh < hi(mreg[3])));
      chk("R6 vSync", int'(vSync), int'(mEn && mv >= lo(mreg[4]) && mv < hi(mreg[4])));
      chk("R7 hRetrace", int'(hRetrace), int'(mEn && mh >= lo(mreg[2]) && mh < hi(mreg[2])));
      chk("R8 vRetrace", int'(vRetrace), int'(mEn && mv >= hi(mreg[1])));
      chk("R9 frameEnd", int'(frameEnd), int'(expFe()));
      chk("R2 videoEn", int'(videoEn), int'(mEn));
    end
  end

  task automatic wr(int addr, bit [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'(addr); wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  int nFe, nHs, nDe, nHr;
  task automatic runFor(int n);
    nFe = 0; nHs = 0; nDe = 0; nHr = 0;
    for (int i = 0; i < n; i++) begin
      nFe += int'(frameEnd); nHs += int'(hSync);
      nDe += int'(dataEn);   nHr += int'(hRetrace);
      @(negedge clk);
    end
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog R1..all actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pixCount", int'(pixCount), 0);
    chk("R1 lineCount", int'(lineCount), 0);
    chk("R1 outputs", int'({dataEn, hSync, vSync, hRetrace, vRetrace, frameEnd, videoEn}), 0);
    cmpOn = 1'b1;

    // R2 geometry A: 12x6 total, 8x4 active
    wr(0, {16'd6, 16'd12});
    wr(1, {16'd4, 16'd8});
    wr(2, {16'd10, 16'd9});
    wr(3, {16'd11, 16'd9});
    wr(4, {16'd5, 16'd4});
    wr(5, 32'h1);
    runFor(144);
    chk("R9 frames continuous", nFe, 2);
    chk("R6 hSync cycles", nHs, 24);
    chk("R5 dataEn cycles", nDe, 64);
    chk("R7 hRetrace cycles", nHr, 12);

    // R11 disable mid-frame
    repeat (17) @(negedge clk);
    wr(5, 32'h0);
    repeat (5) @(negedge clk);
    chk("R11 pixCount held", int'(pixCount), 0);
    chk("R11 lineCount held", int'(lineCount), 0);
    chk("R11 dataEn low", int'(dataEn), 0);

    // geometry B with an empty hsync window, single-frame mode
    wr(0, {16'd5, 16'd10});
    wr(1, {16'd3, 16'd6});
    wr(2, {16'd8, 16'd7});
    wr(3, {16'd5, 16'd5});
    wr(4, {16'd4, 16'd3});
    wr(5, 32'h3);
    runFor(100);
    chk("R10 single frame count", nFe, 1);
    chk("R12 empty hSync window", nHs, 0);
    chk("R10 videoEn cleared", int'(videoEn), 0);
    chk("R10 counters parked", int'(pixCount) + int'(lineCount), 0);

    // R10 retrigger
    wr(5, 32'h3);
    runFor(80);
    chk("R10 retrigger frame count", nFe, 1);
    chk("R10 videoEn cleared again", int'(videoEn), 0);

    cmpOn = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule